// File: doc/BRIEF.md
# PLL Control Register File with Lock-Detect Timer

This block holds the four 32-bit configuration and status words of a phase-locked loop. These are a control/status word, a power word, a feedback-divider word and a post-divider word. Software reaches them over a simple synchronous bus with separate write and read strobes. Reads return data one cycle after the strobe.

The block does not observe a real loop. It produces the lock indication itself from two inputs. The first is a readiness condition: the loop is powered and has a non-zero feedback divider. The second is an arm point on a free-running cycle counter.

- Any write that leaves the loop not ready discards the arm point.
- A write that first makes the loop ready schedules the arm point `LOCK_DELAY` cycles ahead.
- A write that changes the reference or feedback divider while the loop is ready schedules it again.
- A write that changes only the output post-dividers does not move the arm point.

The block also drives the decoded divider values continuously for the clock logic around it.

Top module: `pll_ctrl_regs`

## Requirements
- R1: After reset, the words read back as follows, and `lock` is 0:
  - control/status: 0x0000_0001
  - power: 0x0000_002D
  - feedback divider: 0x0000_0000
  - post-divider: 0x0007_7000
- R2: `addr` is a word index:
  - index 0 selects control/status (byte 0x0).
  - index 1 selects power (0x4).
  - index 2 selects the feedback divider (0x8).
  - index 3 selects the post-divider (0xC).

  A write stores `wdata`. A read returns the word on `rdata` after the next clock edge. Bit 31 of control/status cannot be written, so it reads 0 while `lock` is 0.
- R3: The loop is ready only when all three of these hold:
  - feedback divider bits [11:0] are non-zero;
  - power bit 0 (whole-loop power-down) is clear;
  - power bit 5 (oscillator power-down) is clear.

  Control/status bit 8 (bypass) has no effect on readiness or on `lock`. `lock` is never 1 while the loop is not ready.
- R4: A write that makes a not-yet-armed loop ready arms the timer. `lock` then first reads 1 exactly `LOCK_DELAY-1` clock edges after the edge that captured that write. Once high, `lock` stays high until a write disarms or re-arms the timer.
- R5: A write that makes the loop not ready drops the arm point, and `lock` is 0 after that edge. A later write that makes the loop ready again waits the full delay from the start.
- R6: While the loop is ready, a write that changes the reference divider (control/status bits [5:0]) or the feedback divider (bits [11:0]) re-arms the timer. `lock` is 0 after that edge and then follows the R4 timing.
- R7: These writes leave an existing arm point and `lock` unchanged:
  - a write that changes only post-divider fields;
  - a write that repeats the current divider values.
- R8: The decoded outputs carry the divider fields:
  - `ref_div` is control/status bits [5:0].
  - `post_div1` is post-divider bits [18:16].
  - `post_div2` is post-divider bits [14:12].
  - `fb_div` is feedback bits [11:0].

  A zero value reads as 1 on `ref_div`, `post_div1` and `post_div2`. A zero value stays 0 on `fb_div`.
- R9: A read of control/status returns `lock` in bit 31 and the stored bits in [30:0].

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 2 | Word index (byte offset bits [3:2]) |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid the cycle after `rd_en` |
| lock | output | 1 | Synthesised lock indication |
| ref_div | output | 6 | Decoded reference divider |
| fb_div | output | 12 | Feedback divider |
| post_div1 | output | 3 | Decoded first post-divider |
| post_div2 | output | 3 | Decoded second post-divider |

## Verification
Power words are tried in three ways:
- with the whole-loop power-down bit set;
- with the oscillator power-down bit set;
- with both bits clear and the bypass bit set.

Together these separate the readiness inputs from each other and from bypass.

Lock timing is checked one edge before and at the expected rise. This is done for a fresh arm, for re-arms caused by the reference divider and by the feedback divider, and for an arm after a power-down. An off-by-one in the counter compare, or a re-arm that should not happen, therefore shows up.

Post-divider-only writes and identical rewrites confirm that `lock` stays high. Zero-valued fields confirm the decode to 1 on every output except the feedback divider.

// File: rtl/pll_ctrl_regs.sv
module pll_ctrl_regs #(
  parameter int LOCK_DELAY = 2000,
  parameter int CNT_W      = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic        rd_en,
  input  logic [1:0]  addr,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  output logic        lock,
  output logic [5:0]  ref_div,
  output logic [11:0] fb_div,
  output logic [2:0]  post_div1,
  output logic [2:0]  post_div2
);
  localparam logic [31:0] CS_RST   = 32'h0000_0001;
  localparam logic [31:0] PWR_RST  = 32'h0000_002D;
  localparam logic [31:0] FB_RST   = 32'h0000_0000;
  localparam logic [31:0] POST_RST = 32'h0007_7000;
  localparam logic [CNT_W-1:0] DELAY = CNT_W'(LOCK_DELAY);

  logic [31:0] cs_q, pwr_q, fb_q, post_q;
  logic [31:0] cs_n, pwr_n, fb_n, post_n;
  logic [CNT_W-1:0] cnt_q, target_q;
  logic armed_q;
  logic ready_q, ready_n, cfg_chg;

  assign cs_n   = (wr_en && addr == 2'd0) ? {1'b0, wdata[30:0]} : cs_q;
  assign pwr_n  = (wr_en && addr == 2'd1) ? wdata : pwr_q;
  assign fb_n   = (wr_en && addr == 2'd2) ? wdata : fb_q;
  assign post_n = (wr_en && addr == 2'd3) ? wdata : post_q;

  assign ready_q = (fb_q[11:0] != 12'd0) && !pwr_q[0] && !pwr_q[5];
  assign ready_n = (fb_n[11:0] != 12'd0) && !pwr_n[0] && !pwr_n[5];
  assign cfg_chg = (cs_n[5:0] != cs_q[5:0]) || (fb_n[11:0] != fb_q[11:0]);

  assign lock = armed_q && ready_q && (cnt_q >= target_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cs_q     <= CS_RST;
      pwr_q    <= PWR_RST;
      fb_q     <= FB_RST;
      post_q   <= POST_RST;
      cnt_q    <= '0;
      target_q <= '0;
      armed_q  <= 1'b0;
      rdata    <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
      if (wr_en) begin
        cs_q   <= cs_n;
        pwr_q  <= pwr_n;
        fb_q   <= fb_n;
        post_q <= post_n;
        if (!ready_n) begin
          armed_q <= 1'b0;
        end else if (!armed_q || cfg_chg) begin
          armed_q  <= 1'b1;
          target_q <= cnt_q + DELAY;
        end
      end
      if (rd_en) begin
        case (addr)
          2'd0:    rdata <= {lock, cs_q[30:0]};
          2'd1:    rdata <= pwr_q;
          2'd2:    rdata <= fb_q;
          default: rdata <= post_q;
        endcase
      end
    end
  end

  assign ref_div   = (cs_q[5:0] == 6'd0) ? 6'd1 : cs_q[5:0];
  assign fb_div    = fb_q[11:0];
  assign post_div1 = (post_q[18:16] == 3'd0) ? 3'd1 : post_q[18:16];
  assign post_div2 = (post_q[14:12] == 3'd0) ? 3'd1 : post_q[14:12];
endmodule

// File: rtl/pll_ctrl_regs_chk.sv
module pll_ctrl_regs_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic        rd_en,
  input logic [1:0]  addr,
  input logic [31:0] wdata,
  input logic [31:0] rdata,
  input logic        lock,
  input logic [31:0] pwr_q,
  input logic [5:0]  ref_div,
  input logic [11:0] fb_div,
  input logic [2:0]  post_div1,
  input logic [2:0]  post_div2
);
  assert_lock_ready_R3: assert property (@(posedge clk) disable iff (!rst_n)
    lock |-> (fb_div != 12'd0 && !pwr_q[0] && !pwr_q[5]));

  assert_lock_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (lock && !wr_en) |=> lock);

  assert_pd_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 2'd1 && (wdata[0] || wdata[5])) |=> !lock);

  assert_fb_rearm_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 2'd2 && wdata[11:0] != fb_div && wdata[11:0] != 12'd0)
      |=> !lock);

  assert_post_keep_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (lock && wr_en && addr == 2'd3) |=> lock);

  assert_decode_nonzero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_div != 6'd0 && post_div1 != 3'd0 && post_div2 != 3'd0));

  assert_read_lock_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == 2'd0) |=> (rdata[31] == $past(lock)));
endmodule

bind pll_ctrl_regs pll_ctrl_regs_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
  .wdata(wdata), .rdata(rdata), .lock(lock), .pwr_q(pwr_q),
  .ref_div(ref_div), .fb_div(fb_div), .post_div1(post_div1),
  .post_div2(post_div2)
);

// File: tb/tb_pll_ctrl_regs.sv
`timescale 1ns/1ps
module tb_pll_ctrl_regs;
  localparam int D = 2000;
  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [1:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic lock;
  logic [5:0] ref_div;
  logic [11:0] fb_div;
  logic [2:0] post_div1, post_div2;
  int checks = 0, errors = 0;
  logic done = 1'b0;

  always #5 clk = ~clk;

  pll_ctrl_regs #(.LOCK_DELAY(D)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .lock(lock), .ref_div(ref_div),
    .fb_div(fb_div), .post_div1(post_div1), .post_div2(post_div2));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(posedge clk); #1; wr_en = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, output logic [31:0] d);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(posedge clk); #1; rd_en = 1'b0; d = rdata;
  endtask

  task automatic edges(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic lock_timing(string req);
    chk(req, 32'(lock), 0);
    edges(D - 2);
    chk(req, 32'(lock), 0);
    edges(1);
    chk(req, 32'(lock), 1);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    chk("R1", 32'(lock), 0);
    rd(2'd0, d); chk("R1", d, 32'h0000_0001);
    rd(2'd1, d); chk("R1", d, 32'h0000_002D);
    rd(2'd2, d); chk("R1", d, 32'h0000_0000);
    rd(2'd3, d); chk("R1", d, 32'h0007_7000);
    chk("R8", 32'(ref_div), 1);
    chk("R8", 32'(fb_div), 0);
    chk("R8", 32'(post_div1), 7);
    chk("R8", 32'(post_div2), 7);
  endtask

  task automatic t_regs;
    logic [31:0] d;
    wr(2'd0, 32'h8000_0100);
    rd(2'd0, d); chk("R2", d, 32'h0000_0100);
    chk("R8", 32'(ref_div), 1);
    wr(2'd0, 32'h0000_0103);
    chk("R8", 32'(ref_div), 3);
    wr(2'd3, 32'h0000_0000);
    rd(2'd3, d); chk("R2", d, 32'h0);
    chk("R8", 32'(post_div1), 1);
    chk("R8", 32'(post_div2), 1);
    wr(2'd3, 32'h0005_2000);
    chk("R8", 32'(post_div1), 5);
    chk("R8", 32'(post_div2), 2);
  endtask

  task automatic t_ready;
    logic [31:0] d;
    wr(2'd2, 32'd100);
    chk("R8", 32'(fb_div), 100);
    wr(2'd1, 32'h0000_0001);
    edges(D + 5);
    chk("R3", 32'(lock), 0);
    wr(2'd1, 32'h0000_0020);
    edges(D + 5);
    chk("R3", 32'(lock), 0);
    wr(2'd1, 32'h0000_0000);
    lock_timing("R4");
    rd(2'd0, d); chk("R9", d, 32'h8000_0103);
    chk("R3", 32'(lock), 1);
  endtask

  task automatic t_keep;
    wr(2'd3, 32'h0002_2000);
    chk("R7", 32'(lock), 1);
    wr(2'd2, 32'd100);
    chk("R7", 32'(lock), 1);
    wr(2'd0, 32'h0000_0003);
    chk("R7", 32'(lock), 1);
    chk("R3", 32'(ref_div), 3);
  endtask

  task automatic t_rearm;
    wr(2'd2, 32'd125);
    lock_timing("R6");
    wr(2'd0, 32'h0000_0005);
    lock_timing("R6");
  endtask

  task automatic t_pd;
    wr(2'd1, 32'h0000_002D);
    chk("R5", 32'(lock), 0);
    edges(10);
    wr(2'd1, 32'h0000_0000);
    lock_timing("R5");
    wr(2'd2, 32'd0);
    chk("R5", 32'(lock), 0);
    chk("R8", 32'(fb_div), 0);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(posedge clk);
        #1; rst_n = 1'b1;
        t_reset();
        t_regs();
        t_ready();
        t_keep();
        t_rearm();
        t_pd();
      end
      begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule